// File: doc/BRIEF.md
# Descriptor Ring Walker for a Scatter-Gather DMA Channel

This block is the control engine of one DMA channel. It walks a linked chain of transfer descriptors in memory. Each descriptor is four 32-bit words, read one at a time over a request/acknowledge memory read port. The walker decodes the descriptor and, when it is fit to run, hands its PCI-side address, local-side address, length and direction to an external data mover. It starts the mover with a one-cycle pulse and then waits for the mover's completion pulse before it follows the next pointer.

Software drives a few mode inputs and writes a start bit. A write of one begins a walk at the first-descriptor pointer. A write of zero pauses the channel. Software reads back a run flag and a done flag. An optional ownership gate uses a flag in the descriptor. When the gate is on and the flag is clear, the walker either polls the descriptor after a programmable wait or halts. An end-of-transfer input can cut the link in progress or finish the whole chain, depending on a mode input.

Top module: `sg_ring_walker`

## Requirements
- R1: After reset, sts_run, sts_done, mem_req and mv_start are all 0.
- R2: A descriptor at byte address P is read as four words at P, P+4, P+8 and P+12, in that order. The words are: PCI address, local address, size word and link word. mem_req and mem_addr hold steady until mem_ack. A walk begins its reads at cfg_first_ptr.
- R3: A runnable descriptor with a nonzero length produces exactly one mv_start pulse of one cycle. During that pulse, mv_pci_addr, mv_loc_addr, mv_len (size word bits LEN_W-1:0) and mv_dir (link word bit 3) carry the descriptor's values. These outputs stay unchanged until the transfer ends.
- R4: The link word gives the next descriptor address as bits 31:4 with the low four bits zero. Link bit 1 marks the last descriptor. When the last descriptor completes, sts_done becomes 1 and sts_run becomes 0. sts_done and sts_run are never 1 together.
- R5: With cfg_valid_mode at 0, size word bit 31 has no effect, and descriptors with that bit clear still run.
- R6: With cfg_valid_mode at 1 and cfg_stop_invalid at 0, a descriptor whose bit 31 is 0 starts no transfer. It is re-read after cfg_poll_dly+1 idle cycles, and this repeats until the bit reads 1, after which it runs.
- R7: With cfg_valid_mode at 1 and cfg_stop_invalid at 1, a descriptor whose bit 31 is 0 halts the walk. sts_run drops, sts_done stays 0, and no further reads occur.
- R8: A zero-length descriptor starts no transfer. If it is not last, the walker moves to the next descriptor. If it is last, the chain completes with sts_done set.
- R9: With cfg_eot_link at 1, eot_i during a transfer abandons that link and the walk continues with the next descriptor. At the last descriptor, the chain completes.
- R10: With cfg_eot_link at 0, eot_i during a transfer ends the chain, with sts_done set and no later transfers. This holds also when eot_i and mv_done arrive in the same cycle.
- R11: A start write of 0 while running pauses the channel. On the next cycle sts_done is 1 and sts_run is 0, and no reads or transfers follow.
- R12: A start write of 1 clears sts_done, sets sts_run and restarts the walk at cfg_first_ptr, including after a halt.
- R13: eot_i has no effect when no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid_mode | input | 1 | Enables gating on size word bit 31 |
| cfg_stop_invalid | input | 1 | 1: halt on a non-owned descriptor, 0: poll it |
| cfg_eot_link | input | 1 | 1: eot_i cuts the current link, 0: eot_i ends the chain |
| cfg_poll_dly | input | POLL_W | Idle cycles between polls, minus one |
| cfg_first_ptr | input | 32 | Address of the first descriptor |
| ctl_start_wr | input | 1 | Write strobe for the start bit |
| ctl_start_val | input | 1 | Start bit value written |
| sts_run | output | 1 | Channel is walking |
| sts_done | output | 1 | Chain finished or paused |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| mv_pci_addr | output | 32 | PCI-side start address |
| mv_loc_addr | output | 32 | Local-side start address |
| mv_len | output | LEN_W | Transfer length |
| mv_dir | output | 1 | Transfer direction |
| mv_done | input | 1 | Data mover completion pulse |
| eot_i | input | 1 | End-of-transfer request |

## Verification
The mover's completion pulse and the end-of-transfer input can both reach the walker in the same cycle while a transfer is in flight. The model of the mover raises both on a chosen transfer, in random and directed runs, with the chain-ending mode selected. The outcome is judged by the list of issued transfers: it must stop at that transfer, with done set and run clear. A further run holds end-of-transfer high whenever no transfer is pending, and must see the full chain issued.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F_PCI,
    ST_F_LOC,
    ST_F_SIZE,
    ST_F_NEXT,
    ST_CHECK,
    ST_XFER,
    ST_NEXT,
    ST_POLL,
    ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [31:0] pci;
    logic [31:0] loc;
    logic [31:0] size;
    logic [31:0] link;
  } desc_t;

  // byte address of word idx inside the descriptor at base
  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [1:0] idx);
    return base + {28'd0, idx, 2'b00};
  endfunction

  function automatic logic desc_owned(input logic [31:0] size);
    return size[31];
  endfunction

  function automatic logic link_last(input logic [31:0] link);
    return link[1];
  endfunction

  function automatic logic link_dir(input logic [31:0] link);
    return link[3];
  endfunction

  function automatic logic [31:0] link_ptr(input logic [31:0] link);
    return {link[31:4], 4'b0000};
  endfunction

endpackage

// File: rtl/sgw_run_ctl.sv
module sgw_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_val,
  input  logic chain_end,
  input  logic halt,
  output logic start_set,
  output logic pause,
  output logic run,
  output logic done
);
  assign start_set = start_wr & start_val;
  assign pause     = start_wr & ~start_val & run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start_set) begin
      run  <= 1'b1;
      done <= 1'b0;
    end else if (pause || chain_end) begin
      run  <= 1'b0;
      done <= 1'b1;
    end else if (halt) begin
      run  <= 1'b0;
    end
  end
endmodule

// File: rtl/sgw_poll_timer.sv
module sgw_poll_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dly,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic         armed_q;

  assign expired = armed_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= dly;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sgw_desc_latch.sv
module sgw_desc_latch
  import sgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic [1:0]  idx,
  input  logic [31:0] word,
  output desc_t       desc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc <= '0;
    end else if (cap) begin
      case (idx)
        2'd0:    desc.pci  <= word;
        2'd1:    desc.loc  <= word;
        2'd2:    desc.size <= word;
        default: desc.link <= word;
      endcase
    end
  end
endmodule

// File: rtl/sg_ring_walker.sv
module sg_ring_walker
  import sgw_pkg::*;
#(
  parameter int LEN_W  = 23,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid_mode,
  input  logic              cfg_stop_invalid,
  input  logic              cfg_eot_link,
  input  logic [POLL_W-1:0] cfg_poll_dly,
  input  logic [31:0]       cfg_first_ptr,
  input  logic              ctl_start_wr,
  input  logic              ctl_start_val,
  output logic              sts_run,
  output logic              sts_done,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              mv_start,
  output logic [31:0]       mv_pci_addr,
  output logic [31:0]       mv_loc_addr,
  output logic [LEN_W-1:0]  mv_len,
  output logic              mv_dir,
  input  logic              mv_done,
  input  logic              eot_i
);
  walk_st_e    st_q, st_d;
  logic [31:0] ptr_q;
  logic        mv_start_q;
  desc_t       desc;
  logic        start_set, pause;
  logic        fetching;
  logic [1:0]  fidx;
  logic        poll_exp;
  logic        d_gate, d_zero, d_last;

  // named events, also seen by the checker
  logic ev_launch, ev_skip, ev_poll, ev_halt, ev_chain_end, xfer_busy;

  wire unused_desc_bits = ^{desc.size[30:LEN_W], desc.link[2], desc.link[0]};

  sgw_run_ctl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_wr  (ctl_start_wr),
    .start_val (ctl_start_val),
    .chain_end (ev_chain_end),
    .halt      (ev_halt),
    .start_set (start_set),
    .pause     (pause),
    .run       (sts_run),
    .done      (sts_done)
  );

  sgw_poll_timer #(.W(POLL_W)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_poll),
    .dly     (cfg_poll_dly),
    .expired (poll_exp)
  );

  sgw_desc_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (fetching && mem_ack),
    .idx   (fidx),
    .word  (mem_rdata),
    .desc  (desc)
  );

  always_comb begin
    fetching = 1'b1;
    fidx     = 2'd0;
    case (st_q)
      ST_F_PCI:  fidx = 2'd0;
      ST_F_LOC:  fidx = 2'd1;
      ST_F_SIZE: fidx = 2'd2;
      ST_F_NEXT: fidx = 2'd3;
      default:   fetching = 1'b0;
    endcase
  end

  assign mem_req  = fetching;
  assign mem_addr = word_addr(ptr_q, fidx);

  assign d_gate       = cfg_valid_mode && !desc_owned(desc.size);
  assign d_zero       = (desc.size[LEN_W-1:0] == '0);
  assign d_last       = link_last(desc.link);
  assign ev_chain_end = (st_q == ST_DONE);
  assign xfer_busy    = (st_q == ST_XFER);

  always_comb begin
    st_d      = st_q;
    ev_launch = 1'b0;
    ev_skip   = 1'b0;
    ev_poll   = 1'b0;
    ev_halt   = 1'b0;
    if (start_set) begin
      st_d = ST_F_PCI;
    end else if (pause) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:   st_d = ST_IDLE;
        ST_F_PCI:  if (mem_ack) st_d = ST_F_LOC;
        ST_F_LOC:  if (mem_ack) st_d = ST_F_SIZE;
        ST_F_SIZE: if (mem_ack) st_d = ST_F_NEXT;
        ST_F_NEXT: if (mem_ack) st_d = ST_CHECK;
        ST_CHECK: begin
          if (d_gate) begin
            if (cfg_stop_invalid) begin
              ev_halt = 1'b1;
              st_d    = ST_IDLE;
            end else begin
              ev_poll = 1'b1;
              st_d    = ST_POLL;
            end
          end else if (d_zero) begin
            ev_skip = !d_last;
            st_d    = d_last ? ST_DONE : ST_NEXT;
          end else begin
            ev_launch = 1'b1;
            st_d      = ST_XFER;
          end
        end
        ST_XFER: begin
          // end-of-transfer outranks a completion in the same cycle
          if (eot_i) begin
            st_d = (cfg_eot_link && !d_last) ? ST_NEXT : ST_DONE;
          end else if (mv_done) begin
            st_d = d_last ? ST_DONE : ST_NEXT;
          end
        end
        ST_NEXT:  st_d = ST_F_PCI;
        ST_POLL:  if (poll_exp) st_d = ST_F_PCI;
        ST_DONE:  st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      mv_start_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      mv_start_q <= ev_launch;
      if (start_set) begin
        ptr_q <= cfg_first_ptr;
      end else if (st_q == ST_NEXT && !pause) begin
        ptr_q <= link_ptr(desc.link);
      end
    end
  end

  assign mv_start    = mv_start_q;
  assign mv_pci_addr = desc.pci;
  assign mv_loc_addr = desc.loc;
  assign mv_len      = desc.size[LEN_W-1:0];
  assign mv_dir      = link_dir(desc.link);

endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_start_wr,
  input logic        ctl_start_val,
  input logic        sts_run,
  input logic        sts_done,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        mv_start,
  input logic [31:0] mv_pci_addr,
  input logic [31:0] mv_loc_addr,
  input logic        xfer_busy,
  input logic        ev_skip,
  input logic        ev_halt
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !ctl_start_wr |=> mem_req && $stable(mem_addr));

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  // R3
  start_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> xfer_busy && sts_run);

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy && $past(xfer_busy) |-> $stable(mv_pci_addr) && $stable(mv_loc_addr));

  // R4
  run_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_run && sts_done));

  // R7
  halt_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> !sts_run && !sts_done);

  // R8
  skip_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> !mv_start);

  // R11
  pause_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start_wr && !ctl_start_val && sts_run |=> sts_done && !sts_run);

  // R11
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> sts_run);
endmodule

bind sg_ring_walker sgw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_start_wr  (ctl_start_wr),
  .ctl_start_val (ctl_start_val),
  .sts_run       (sts_run),
  .sts_done      (sts_done),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .mv_start      (mv_start),
  .mv_pci_addr   (mv_pci_addr),
  .mv_loc_addr   (mv_loc_addr),
  .xfer_busy     (xfer_busy),
  .ev_skip       (ev_skip),
  .ev_halt       (ev_halt)
);

// File: tb/sg_ring_walker_bench.sv
`timescale 1ns/1ps
module sg_ring_walker_bench;
  localparam int LEN_W  = 23;
  localparam int POLL_W = 8;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid_mode = 0, cfg_stop_invalid = 0, cfg_eot_link = 0;
  logic [POLL_W-1:0] cfg_poll_dly = 8'd5;
  logic [31:0] cfg_first_ptr = BASE;
  logic ctl_start_wr = 0, ctl_start_val = 0;
  logic mem_ack = 0, mv_done = 0, eot_i = 0;
  logic [31:0] mem_rdata = '0;
  wire sts_run, sts_done, mem_req, mv_start, mv_dir;
  wire [31:0] mem_addr, mv_pci_addr, mv_loc_addr;
  wire [LEN_W-1:0] mv_len;

  always #2 clk = ~clk;

  sg_ring_walker #(.LEN_W(LEN_W), .POLL_W(POLL_W)) u_sg_ring_walker (
    .clk(clk), .rst_n(rst_n), .cfg_valid_mode(cfg_valid_mode),
    .cfg_stop_invalid(cfg_stop_invalid), .cfg_eot_link(cfg_eot_link),
    .cfg_poll_dly(cfg_poll_dly), .cfg_first_ptr(cfg_first_ptr),
    .ctl_start_wr(ctl_start_wr), .ctl_start_val(ctl_start_val),
    .sts_run(sts_run), .sts_done(sts_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_pci_addr(mv_pci_addr), .mv_loc_addr(mv_loc_addr),
    .mv_len(mv_len), .mv_dir(mv_dir), .mv_done(mv_done), .eot_i(eot_i));

  logic [31:0] mem [0:63];
  int rd_cnt [0:63];
  int rd_total = 0, mwait = 0;
  logic [31:0] first_rd_addr;
  bit first_rd_seen = 0;

  int total = 0, fails = 0;
  // mover model state
  bit busy = 0, eot_both = 0, eot_noise = 0;
  int mcnt = 0, mv_dly_min = 1, cur_idx = 0, eot_at = -1, n_obs = 0;
  logic [31:0] o_pci [0:63], o_loc [0:63];
  int o_len [0:63];
  bit o_dir [0:63];
  // expected
  logic [31:0] e_pci [0:63], e_loc [0:63];
  int e_len [0:63];
  bit e_dir [0:63];
  int n_exp = 0;
  bit e_done = 1;

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (mwait == 0) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[(mem_addr >> 2) & 63];
        rd_cnt[(mem_addr >> 2) & 63]++;
        rd_total++;
        if (!first_rd_seen) begin first_rd_seen = 1; first_rd_addr = mem_addr; end
        mwait = $urandom % 3;
      end else mwait--;
    end
  end

  // data mover model and transfer monitor
  always @(negedge clk) begin
    bit prev_done, fired;
    prev_done = mv_done;
    fired = 0;
    mv_done = 1'b0;
    eot_i   = 1'b0;
    if (mv_start) begin
      if (n_obs < 64) begin
        o_pci[n_obs] = mv_pci_addr; o_loc[n_obs] = mv_loc_addr;
        o_len[n_obs] = int'(mv_len); o_dir[n_obs] = mv_dir;
      end
      n_obs++;
      busy = 1;
      mcnt = mv_dly_min + ($urandom % 4);
    end else if (busy) begin
      if (mcnt == 0) begin
        busy = 0; fired = 1;
        if (cur_idx == eot_at) begin eot_i = 1'b1; mv_done = eot_both; end
        else mv_done = 1'b1;
        cur_idx++;
      end else mcnt--;
    end
    if (eot_noise && !busy && !prev_done && !fired) eot_i = 1'b1;
  end

  task automatic chk_eq(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int slot, input logic [31:0] pci, input logic [31:0] loc,
                          input int len, input bit own, input int nslot, input bit last,
                          input bit dir);
    mem[slot*4]   = pci;
    mem[slot*4+1] = loc;
    mem[slot*4+2] = {own, 8'h00, len[LEN_W-1:0]};
    mem[slot*4+3] = BASE + 32'(nslot * 16) + {28'd0, dir, 1'b0, last, 1'b0};
  endtask

  // bench model of a walk over the array
  task automatic model(input int first_slot);
    int slot, k;
    slot = first_slot; k = 0; n_exp = 0; e_done = 1;
    for (int step = 0; step < 40; step++) begin
      logic [31:0] sz, lk;
      sz = mem[slot*4+2];
      lk = mem[slot*4+3];
      if (cfg_valid_mode && !sz[31]) begin e_done = 0; break; end
      if (sz[LEN_W-1:0] != 0) begin
        e_pci[n_exp] = mem[slot*4]; e_loc[n_exp] = mem[slot*4+1];
        e_len[n_exp] = int'(sz[LEN_W-1:0]); e_dir[n_exp] = lk[3];
        n_exp++;
        if (k == eot_at && !cfg_eot_link) break;
        k++;
      end
      if (lk[1]) break;
      slot = int'(lk[7:4]);
    end
  endtask

  task automatic pulse_start(input bit val);
    @(negedge clk); ctl_start_wr = 1; ctl_start_val = val;
    @(negedge clk); ctl_start_wr = 0;
  endtask

  task automatic begin_run();
    n_obs = 0; cur_idx = 0; first_rd_seen = 0;
    for (int i = 0; i < 64; i++) rd_cnt[i] = 0;
    pulse_start(1'b1);
  endtask

  task automatic wait_idle(input string req);
    bit ok;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!sts_run) begin ok = 1; break; end
      @(negedge clk);
    end
    chk_eq({req, " walk ends"}, ok, 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk_eq({req, " transfer count"}, n_obs, n_exp);
    for (int i = 0; i < n_exp && i < n_obs; i++) begin
      chk_eq({req, " pci addr"}, o_pci[i], e_pci[i]);
      chk_eq({req, " local addr"}, o_loc[i], e_loc[i]);
      chk_eq({req, " length"}, o_len[i], e_len[i]);
      chk_eq({req, " direction"}, o_dir[i], e_dir[i]);
    end
    chk_eq({req, " done flag"}, sts_done, e_done);
    chk_eq({req, " run flag"}, sts_run, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, rt;
    int perm [0:15];
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin mem[i] = '0; rd_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 run", sts_run, 0);
    chk_eq("R1 done", sts_done, 0);
    chk_eq("R1 mem_req", mem_req, 0);
    chk_eq("R1 mv_start", mv_start, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5: mode off, second descriptor not owned but still runs
    cfg_valid_mode = 0;
    put_desc(3, 32'hA000_0000, 32'h0000_1000, 64, 1, 7, 0, 1);
    put_desc(7, 32'hA000_0100, 32'h0000_2000, 12, 0, 1, 0, 0);
    put_desc(1, 32'hA000_0200, 32'h0000_3000, 5, 1, 0, 1, 1);
    cfg_first_ptr = BASE + 32'd48;
    model(3); begin_run(); wait_idle("R4");
    compare("R3 R4 R5 chain");
    chk_eq("R2 first read address", first_rd_addr, BASE + 32'd48);
    chk_eq("R2 link word read once", rd_cnt[3*4+3], 1);

    // R8 zero-length skip, then zero-length last
    put_desc(0, 32'hB000_0000, 32'h10, 8, 1, 1, 0, 0);
    put_desc(1, 32'hB000_0100, 32'h20, 0, 1, 2, 0, 0);
    put_desc(2, 32'hB000_0200, 32'h30, 9, 1, 3, 0, 1);
    put_desc(3, 32'hB000_0300, 32'h40, 0, 1, 0, 1, 0);
    cfg_first_ptr = BASE; cfg_valid_mode = 1;
    model(0); begin_run(); wait_idle("R8");
    compare("R8 zero skip");

    // R6 polling a non-owned descriptor
    cfg_stop_invalid = 0; cfg_poll_dly = 8'd5;
    put_desc(0, 32'hC000_0000, 32'h50, 100, 0, 0, 1, 0);
    begin_run();
    repeat (80) @(negedge clk);
    chk_eq("R6 no transfer while not owned", n_obs, 0);
    chk_eq("R6 descriptor re-read", rd_cnt[0] >= 2, 1);
    chk_eq("R6 still running", sts_run, 1);
    mem[2][31] = 1'b1;
    model(0); wait_idle("R6");
    compare("R6 after ownership");

    // R7 halt on non-owned, then R12 restart
    cfg_stop_invalid = 1;
    put_desc(0, 32'hD000_0000, 32'h60, 16, 1, 1, 0, 0);
    put_desc(1, 32'hD000_0100, 32'h70, 32, 0, 0, 1, 1);
    model(0); begin_run(); wait_idle("R7");
    compare("R7 halt");
    rt = rd_total;
    repeat (30) @(negedge clk);
    chk_eq("R7 no reads after halt", rd_total, rt);
    mem[1*4+2][31] = 1'b1;
    model(0); begin_run(); wait_idle("R12");
    compare("R12 restart");
    chk_eq("R12 restart address", first_rd_addr, BASE);

    // R9 cut the link, walk continues
    cfg_valid_mode = 0; cfg_eot_link = 1; eot_at = 1; eot_both = 0;
    put_desc(0, 32'hE000_0000, 32'h80, 4, 1, 1, 0, 0);
    put_desc(1, 32'hE000_0100, 32'h90, 4, 1, 2, 0, 1);
    put_desc(2, 32'hE000_0200, 32'hA0, 4, 1, 0, 1, 0);
    model(0); begin_run(); wait_idle("R9");
    compare("R9 link cut");

    // R10 end chain, then end chain with done in same cycle
    cfg_eot_link = 0;
    model(0); begin_run(); wait_idle("R10");
    compare("R10 chain end");
    eot_both = 1; eot_at = 0;
    model(0); begin_run(); wait_idle("R10");
    compare("R10 eot with done same cycle");
    eot_at = -1; eot_both = 0;

    // R13 eot outside a transfer
    eot_noise = 1;
    model(0); begin_run(); wait_idle("R13");
    compare("R13 idle eot ignored");
    eot_noise = 0;

    // R11 pause during a transfer
    mv_dly_min = 40;
    begin_run();
    for (int i = 0; i < 200 && n_obs == 0; i++) @(negedge clk);
    pulse_start(1'b0);
    chk_eq("R11 done after pause", sts_done, 1);
    chk_eq("R11 run after pause", sts_run, 0);
    rt = rd_total;
    repeat (60) @(negedge clk);
    chk_eq("R11 no reads after pause", rd_total, rt);
    chk_eq("R11 no new transfers", n_obs, 1);
    mv_dly_min = 1;

    // random chains
    for (int it = 0; it < 20; it++) begin
      for (int i = 0; i < 16; i++) perm[i] = i;
      for (int i = 15; i > 0; i--) begin
        int j, t;
        j = $urandom % (i + 1); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      n = 2 + $urandom % 5;
      cfg_valid_mode = $urandom % 2;
      cfg_eot_link = $urandom % 2;
      eot_at = ($urandom % 2) ? -1 : int'($urandom % 3);
      eot_both = $urandom % 2;
      for (int i = 0; i < n; i++)
        put_desc(perm[i], $urandom, $urandom, ($urandom % 4 == 0) ? 0 : 1 + $urandom % 1000,
                 1, perm[(i + 1) % 16], (i == n - 1), $urandom % 2);
      cfg_first_ptr = BASE + 32'(perm[0] * 16);
      model(perm[0]); begin_run(); wait_idle("R3");
      compare("R3 R8 R9 R10 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule